// File: doc/BRIEF.md
# Variable-Width Bus Inversion Line Codec

This block sits between a line compressor and the memory channel. A compressed line of 1 to 32 bytes enters with its byte length. The block leaves a whole number of 8-byte beats on the bus. The space after the payload in the final beat is spare, and the block fills it with an inversion mask of zero to three bytes. It uses as many of those bytes as fit, up to three. The mask has one bit per payload word. The word width is chosen per line so that the mask bits cover the whole payload. Each word is sent either as it is or bit-flipped, whichever flips fewer bus wires relative to the word sent just before it. A 2-bit tag travels beside every beat and gives the mask length, so the far side can find and apply the mask.

The return path takes the beats back, together with the length and tag that were stored alongside them. It rebuilds the line, reads the mask from the bytes that follow the payload, flips the marked words back, and presents the exact original payload.

Top module: `vdbi_codec`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `dec_out_valid` is 0.
- R2: For a line of L bytes, every beat carries `out_tag` = min(3, 8*ceil(L/8) - L). The tag value is the number of mask bytes.
- R3: A line of L bytes is sent as exactly ceil(L/8) beats. The first beat appears in the cycle after acceptance, and `out_last` is 1 on the final beat only.
- R4: With tag T > 0, words are W = ceil(L/(8T)) bytes wide, and word i covers bytes iW to iW+W-1. Only bytes below L are counted. A word is sent inverted exactly when more than half of its counted bits differ from the same bits of the word sent before it. Before word 0 the reference is all zeros.
- R5: Image layout: bytes 0 to L-1 hold the coded payload and bytes L to L+T-1 hold the mask. Bit b of mask byte k marks word 8k+b. All later bytes are zero. Beat n carries bytes 8n to 8n+7, with the lower byte in the lower bits.
- R6: When T is 0, the payload is sent unchanged.
- R7: Input payload bytes at index L or above have no effect on the beats.
- R8: Counted over words of W bytes using only bytes below L, the number of bit changes between consecutive sent words never exceeds that of the raw payload.
- R9: The return path presents `dec_out_valid` in the cycle after the beat marked last. `dec_out_data` then equals the original payload, with bytes at index L and above set to zero.
- R10: `in_ready` stays 0 while a line is being sent. While `out_ready` is 0, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Line offered |
| in_ready | output | 1 | Line can be accepted |
| in_len | input | 6 | Payload length in bytes, 1..32 |
| in_data | input | 256 | Payload, byte 0 in bits 7:0 |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Sink takes beat |
| out_data | output | 64 | Coded beat |
| out_last | output | 1 | Final beat of the line |
| out_tag | output | 2 | Mask size in bytes |
| dec_in_valid | input | 1 | Returning beat valid |
| dec_in_data | input | 64 | Returning beat |
| dec_in_last | input | 1 | Final returning beat |
| dec_in_len | input | 6 | Stored payload length, sampled with the last beat |
| dec_in_tag | input | 2 | Stored mask size, sampled with the last beat |
| dec_out_valid | output | 1 | Restored line valid, one-cycle pulse |
| dec_out_data | output | 256 | Restored payload |

## Verification
The assertions assume that `in_len` lies between 1 and 32 whenever `in_valid` is high. They also assume the return path receives ceil(L/8) beats starting from an empty beat counter, with the length and tag that the encoder produced for that line. The bench offers only legal lengths. It feeds the return path only with beats it has just collected from the output, together with the tag read from those beats. Back-pressure is applied only to the outgoing beat stream, which is the one point where the block must hold its outputs.

// File: rtl/vdbi_pkg.sv
package vdbi_pkg;
   // mask bytes that fit in the unused tail of the final beat, capped
   function automatic int unsigned code_bytes(input int unsigned len,
                                              input int unsigned beat,
                                              input int unsigned maxc);
      int unsigned spare;
      spare = ((len + beat - 1) / beat) * beat - len;
      return (spare > maxc) ? maxc : spare;
   endfunction

   // bytes per word so that 8*code flag bits cover the payload
   function automatic int unsigned word_bytes(input int unsigned len,
                                              input int unsigned code);
      return (code == 0) ? 1 : (len + 8 * code - 1) / (8 * code);
   endfunction
endpackage

// File: rtl/vdbi_word_chain.sv
module vdbi_word_chain #(
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 1,
   parameter int LEN_W      = 6
) (
   input  logic [LINE_BYTES*8-1:0] raw,
   input  logic [LEN_W-1:0]        len,
   output logic [LINE_BYTES*8-1:0] sent,
   output logic [LINE_BYTES-1:0]   flags
);
   localparam int NW  = (LINE_BYTES + WORD_BYTES - 1) / WORD_BYTES;
   localparam int WB  = 8 * WORD_BYTES;
   localparam int PAD = NW * WB;

   logic [PAD-1:0] pad_in, pad_out;
   logic [WB-1:0]  prev, cur, live, sel;
   int             nlive, diff;

   // serial decision: each word compares against the word actually sent before it
   always_comb begin
      pad_in = '0;
      pad_in[LINE_BYTES*8-1:0] = raw;
      pad_out = '0;
      prev    = '0;
      cur     = '0;
      live    = '0;
      sel     = '0;
      flags   = '0;
      nlive   = 0;
      diff    = 0;
      for (int i = 0; i < NW; i++) begin
         cur   = pad_in[i*WB +: WB];
         nlive = 0;
         for (int k = 0; k < WORD_BYTES; k++) begin
            if (i * WORD_BYTES + k < int'(len)) begin
               live[k*8 +: 8] = 8'hFF;
               nlive = nlive + 1;
            end else begin
               live[k*8 +: 8] = 8'h00;
            end
         end
         diff = $countones((cur ^ prev) & live);
         if (nlive > 0 && 2 * diff > 8 * nlive) begin
            sel      = ~cur;
            flags[i] = 1'b1;
         end else begin
            sel = cur;
         end
         pad_out[i*WB +: WB] = sel;
         prev = sel;
      end
      sent = pad_out[LINE_BYTES*8-1:0];
   end
endmodule

// File: rtl/vdbi_line_encoder.sv
module vdbi_line_encoder #(
   parameter int LINE_BYTES = 32,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_CODE   = 3,
   parameter int LEN_W      = 6,
   parameter int TAG_W      = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LINE_BYTES*8-1:0] raw,
   input  logic [LEN_W-1:0]        len,
   output logic [LINE_BYTES*8-1:0] image,
   output logic [TAG_W-1:0]        tag
);
   localparam int WMAX = (LINE_BYTES + 7) / 8;
   localparam int FLW  = 8 * MAX_CODE;

   logic [WMAX-1:0][LINE_BYTES*8-1:0] sent_v;
   logic [WMAX-1:0][LINE_BYTES-1:0]   flag_v;
   logic [LINE_BYTES*8-1:0]           sent_sel;
   logic [LINE_BYTES-1:0]             flag_sel;
   logic [LINE_BYTES+FLW-1:0]         flag_pad;
   logic [FLW-1:0]                    flag_code;
   int unsigned                       code_i, word_i;

   assign code_i = vdbi_pkg::code_bytes(int'(len), BEAT_BYTES, MAX_CODE);
   assign word_i = vdbi_pkg::word_bytes(int'(len), code_i);
   assign tag    = TAG_W'(code_i);

   // one decision chain per legal word width
   for (genvar gw = 1; gw <= WMAX; gw++) begin : g_width
      vdbi_word_chain #(
         .LINE_BYTES (LINE_BYTES),
         .WORD_BYTES (gw),
         .LEN_W      (LEN_W)
      ) u_chain (
         .raw   (raw),
         .len   (len),
         .sent  (sent_v[gw-1]),
         .flags (flag_v[gw-1])
      );
   end

   always_comb begin
      if (code_i == 0) begin
         sent_sel = raw;
         flag_sel = '0;
      end else begin
         sent_sel = sent_v[word_i-1];
         flag_sel = flag_v[word_i-1];
      end
      flag_pad  = {{FLW{1'b0}}, flag_sel};
      flag_code = flag_pad[FLW-1:0];
   end

   always_comb begin
      image = '0;
      for (int j = 0; j < LINE_BYTES; j++) begin
         if (j < int'(len))
            image[j*8 +: 8] = sent_sel[j*8 +: 8];
         else if (j < int'(len) + int'(code_i))
            image[j*8 +: 8] = flag_code[(j - int'(len))*8 +: 8];
      end
   end

   // R4: no word beyond the flag budget may be marked
   p_flag_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i != 0) |-> ((flag_sel >> (8 * code_i)) == '0));
endmodule

// File: rtl/vdbi_line_decoder.sv
module vdbi_line_decoder #(
   parameter int LINE_BYTES = 32,
   parameter int MAX_CODE   = 3,
   parameter int LEN_W      = 6,
   parameter int TAG_W      = 2
) (
   input  logic [LINE_BYTES*8-1:0] image,
   input  logic [LEN_W-1:0]        len,
   input  logic [TAG_W-1:0]        tag,
   output logic [LINE_BYTES*8-1:0] payload
);
   localparam int WMAX = (LINE_BYTES + 7) / 8;
   localparam int FLW  = 8 * MAX_CODE;

   logic [FLW-1:0]                    flag_code;
   logic [LINE_BYTES+FLW-1:0]         flag_pad;
   logic [LINE_BYTES-1:0]             flag_wide;
   logic [WMAX-1:0][LINE_BYTES*8-1:0] rest_v;
   int unsigned                       word_i;

   assign word_i = vdbi_pkg::word_bytes(int'(len), int'(tag));

   always_comb begin
      flag_code = '0;
      for (int k = 0; k < MAX_CODE; k++) begin
         if (k < int'(tag) && int'(len) + k < LINE_BYTES)
            flag_code[k*8 +: 8] = image[(int'(len) + k)*8 +: 8];
      end
      flag_pad  = {{LINE_BYTES{1'b0}}, flag_code};
      flag_wide = flag_pad[LINE_BYTES-1:0];
   end

   for (genvar gw = 1; gw <= WMAX; gw++) begin : g_width
      logic [LINE_BYTES*8-1:0] rest;
      always_comb begin
         for (int j = 0; j < LINE_BYTES; j++)
            rest[j*8 +: 8] = image[j*8 +: 8] ^ {8{flag_wide[j / gw]}};
      end
      assign rest_v[gw-1] = rest;
   end

   always_comb begin
      payload = '0;
      for (int j = 0; j < LINE_BYTES; j++) begin
         if (j < int'(len))
            payload[j*8 +: 8] = (tag == '0) ? image[j*8 +: 8]
                                            : rest_v[word_i-1][j*8 +: 8];
      end
   end
endmodule

// File: rtl/vdbi_codec.sv
module vdbi_codec #(
   parameter  int LINE_BYTES = 32,
   parameter  int BEAT_BYTES = 8,
   parameter  int MAX_CODE   = 3,
   localparam int LEN_W      = $clog2(LINE_BYTES + 1),
   localparam int BEAT_W     = BEAT_BYTES * 8,
   localparam int LINE_W     = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [LINE_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BEAT_W-1:0] out_data,
   output logic              out_last,
   output logic [1:0]        out_tag,
   input  logic              dec_in_valid,
   input  logic [BEAT_W-1:0] dec_in_data,
   input  logic              dec_in_last,
   input  logic [LEN_W-1:0]  dec_in_len,
   input  logic [1:0]        dec_in_tag,
   output logic              dec_out_valid,
   output logic [LINE_W-1:0] dec_out_data
);
   localparam int NBEAT = LINE_BYTES / BEAT_BYTES;
   localparam int CNT_W = (NBEAT > 1) ? $clog2(NBEAT) : 1;

   if (LINE_BYTES % BEAT_BYTES != 0) begin : g_bad_beat
      $error("line size must be a whole number of beats");
   end
   if (MAX_CODE < 1 || MAX_CODE > 3) begin : g_bad_code
      $error("mask size must be 1..3 bytes to fit a 2-bit tag");
   end

   logic [LINE_W-1:0] in_mask, line_q, enc_img, dec_buf_q;
   logic [LEN_W-1:0]  len_q, dec_len_q;
   logic [1:0]        enc_tag, dec_tag_q;
   logic              busy_q, dec_done_q;
   logic [CNT_W-1:0]  beat_q, dec_cnt_q;
   int                nbeat_i;

   // bytes past the stated length never reach the coder
   always_comb begin
      for (int j = 0; j < LINE_BYTES; j++)
         in_mask[j*8 +: 8] = (j < int'(in_len)) ? in_data[j*8 +: 8] : 8'h00;
   end

   assign nbeat_i   = (int'(len_q) + BEAT_BYTES - 1) / BEAT_BYTES;
   assign in_ready  = !busy_q;
   assign out_valid = busy_q;
   assign out_last  = busy_q && (int'(beat_q) == nbeat_i - 1);
   assign out_data  = enc_img[beat_q*BEAT_W +: BEAT_W];
   assign out_tag   = enc_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         len_q  <= '0;
         busy_q <= 1'b0;
         beat_q <= '0;
      end else if (in_valid && !busy_q) begin
         line_q <= in_mask;
         len_q  <= in_len;
         busy_q <= 1'b1;
         beat_q <= '0;
      end else if (busy_q && out_ready) begin
         if (out_last) busy_q <= 1'b0;
         else          beat_q <= beat_q + 1'b1;
      end
   end

   vdbi_line_encoder #(
      .LINE_BYTES (LINE_BYTES),
      .BEAT_BYTES (BEAT_BYTES),
      .MAX_CODE   (MAX_CODE),
      .LEN_W      (LEN_W),
      .TAG_W      (2)
   ) u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (line_q),
      .len   (len_q),
      .image (enc_img),
      .tag   (enc_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_buf_q  <= '0;
         dec_cnt_q  <= '0;
         dec_len_q  <= '0;
         dec_tag_q  <= '0;
         dec_done_q <= 1'b0;
      end else begin
         dec_done_q <= dec_in_valid && dec_in_last;
         if (dec_in_valid) begin
            dec_buf_q[dec_cnt_q*BEAT_W +: BEAT_W] <= dec_in_data;
            if (dec_in_last) begin
               dec_cnt_q <= '0;
               dec_len_q <= dec_in_len;
               dec_tag_q <= dec_in_tag;
            end else begin
               dec_cnt_q <= dec_cnt_q + 1'b1;
            end
         end
      end
   end

   vdbi_line_decoder #(
      .LINE_BYTES (LINE_BYTES),
      .MAX_CODE   (MAX_CODE),
      .LEN_W      (LEN_W),
      .TAG_W      (2)
   ) u_dec (
      .image   (dec_buf_q),
      .len     (dec_len_q),
      .tag     (dec_tag_q),
      .payload (dec_out_data)
   );

   assign dec_out_valid = dec_done_q;

   // input assumption used by R2/R3
   p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_len >= 1 && int'(in_len) <= LINE_BYTES));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));
   p_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);
   p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);
   p_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_tag == 2'd0) |-> (out_data == line_q[beat_q*BEAT_W +: BEAT_W]));
   p_dec_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid |-> $past(dec_in_valid && dec_in_last));
endmodule

// File: tb/vdbi_codec_tb.sv
`timescale 1ns/1ps
module vdbi_codec_tb;
   localparam int LB = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [5:0]   in_len = '0;
   logic [255:0] in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [63:0]  out_data;
   logic         out_last;
   logic [1:0]   out_tag;
   logic         dec_in_valid = 1'b0;
   logic [63:0]  dec_in_data = '0;
   logic         dec_in_last = 1'b0;
   logic [5:0]   dec_in_len = '0;
   logic [1:0]   dec_in_tag = '0;
   logic         dec_out_valid;
   logic [255:0] dec_out_data;

   int n_cmp = 0;
   int n_bad = 0;
   logic [255:0] last_img;

   always #4 clk = ~clk;

   vdbi_codec u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_len (in_len), .in_data (in_data),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .out_last (out_last), .out_tag (out_tag),
      .dec_in_valid (dec_in_valid), .dec_in_data (dec_in_data), .dec_in_last (dec_in_last),
      .dec_in_len (dec_in_len), .dec_in_tag (dec_in_tag),
      .dec_out_valid (dec_out_valid), .dec_out_data (dec_out_data)
   );

   // len, pattern seed, expected tag, expected beats
   localparam logic [31:0] VEC [16] = '{
      {8'd1,  8'hA5, 8'd3, 8'd1}, {8'd5,  8'h3C, 8'd3, 8'd1},
      {8'd6,  8'hF0, 8'd2, 8'd1}, {8'd7,  8'h81, 8'd1, 8'd1},
      {8'd8,  8'h5A, 8'd0, 8'd1}, {8'd9,  8'hC3, 8'd3, 8'd2},
      {8'd14, 8'h17, 8'd2, 8'd2}, {8'd15, 8'hE7, 8'd1, 8'd2},
      {8'd16, 8'h99, 8'd0, 8'd2}, {8'd22, 8'h4B, 8'd2, 8'd3},
      {8'd23, 8'hFF, 8'd1, 8'd3}, {8'd24, 8'h02, 8'd0, 8'd3},
      {8'd29, 8'hD2, 8'd3, 8'd4}, {8'd30, 8'h6E, 8'd2, 8'd4},
      {8'd31, 8'hB1, 8'd1, 8'd4}, {8'd32, 8'h0F, 8'd0, 8'd4}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [255:0] mask_len(input logic [255:0] p, input int len);
      logic [255:0] m = '0;
      for (int j = 0; j < len; j++) m[j*8 +: 8] = p[j*8 +: 8];
      return m;
   endfunction

   // reference image built from R2, R4, R5, R6
   function automatic void mdl(input logic [255:0] p, input int len,
                               output logic [255:0] img, output int tag, output int nb);
      logic [255:0] m;
      logic [31:0]  prev, cur, lm;
      logic [23:0]  fl;
      int spare, w, d, nl;
      m = mask_len(p, len);
      nb = (len + 7) / 8;
      spare = nb * 8 - len;
      tag = (spare > 3) ? 3 : spare;
      img = m;
      fl = '0;
      if (tag > 0) begin
         w = (len + 8 * tag - 1) / (8 * tag);
         prev = '0;
         for (int i = 0; i * w < len; i++) begin
            cur = '0; lm = '0; nl = 0;
            for (int k = 0; k < w; k++)
               if (i * w + k < len) begin
                  cur[k*8 +: 8] = m[(i*w+k)*8 +: 8];
                  lm[k*8 +: 8] = 8'hFF;
                  nl++;
               end
            d = $countones((cur ^ prev) & lm);
            if (2 * d > 8 * nl) begin
               fl[i] = 1'b1;
               cur = ~cur;
            end
            for (int k = 0; k < w; k++)
               if (i * w + k < len) img[(i*w+k)*8 +: 8] = cur[k*8 +: 8];
            prev = cur;
         end
         for (int k = 0; k < tag; k++) img[(len+k)*8 +: 8] = fl[k*8 +: 8];
      end
   endfunction

   function automatic int toggles(input logic [255:0] d, input int len, input int w);
      int s = 0;
      logic [31:0] prev = '0, cur;
      for (int i = 0; i * w < len; i++) begin
         cur = '0;
         for (int k = 0; k < w; k++)
            if (i * w + k < len) cur[k*8 +: 8] = d[(i*w+k)*8 +: 8];
         s += $countones(cur ^ prev);
         prev = cur;
      end
      return s;
   endfunction

   function automatic logic [255:0] pat_line(input logic [7:0] seed);
      logic [255:0] p;
      for (int j = 0; j < LB; j++) p[j*8 +: 8] = 8'(seed * (j + 1)) ^ 8'(j * 8);
      return p;
   endfunction

   // send one line, collect beats, check them, then round-trip through the return path
   task automatic run_line(input logic [255:0] p, input int len, input int xtag, input int xnb);
      logic [255:0] exp_img, got;
      logic [63:0]  beats [4];
      int etag, enb, nb, w;
      bit done;
      mdl(p, len, exp_img, etag, enb);
      got = '0; nb = 0; done = 0;
      @(negedge clk);
      chk(in_ready, "R10", "ready before line", 256'(in_ready), 256'd1);
      in_valid = 1'b1; in_len = 6'(len); in_data = p;
      @(negedge clk);
      in_valid = 1'b0;
      for (int b = 0; b < 4 && !done; b++) begin
         if (b > 0) @(negedge clk);
         chk(out_valid, "R3", "beat valid", 256'(out_valid), 256'd1);
         chk(out_tag == 2'(etag), "R2", "tag", 256'(out_tag), 256'(etag));
         chk(out_last == (b == enb - 1), "R3", "last flag", 256'(out_last), 256'(b == enb - 1));
         beats[b] = out_data;
         got[b*64 +: 64] = out_data;
         nb++;
         if (out_last || !out_valid) done = 1;
      end
      chk(nb == enb, "R3", "beat count", 256'(nb), 256'(enb));
      if (xnb > 0) begin
         chk(etag == xtag, "R2", "table tag", 256'(out_tag), 256'(xtag));
         chk(nb == xnb, "R3", "table beats", 256'(nb), 256'(xnb));
      end
      chk(got == exp_img, "R5", "image", got, exp_img);
      last_img = got;
      w = (etag == 0) ? 1 : (len + 8 * etag - 1) / (8 * etag);
      chk(toggles(mask_len(got, len), len, w) <= toggles(mask_len(p, len), len, w), "R8",
          "toggle count", 256'(toggles(mask_len(got, len), len, w)),
          256'(toggles(mask_len(p, len), len, w)));
      @(negedge clk);
      chk(!out_valid && in_ready, "R3", "idle after last", 256'({out_valid, in_ready}), 256'd1);
      for (int b = 0; b < nb; b++) begin
         if (b > 0) @(negedge clk);
         dec_in_valid = 1'b1; dec_in_data = beats[b]; dec_in_last = (b == nb - 1);
         dec_in_len = 6'(len); dec_in_tag = 2'(etag);
      end
      @(negedge clk);
      dec_in_valid = 1'b0; dec_in_last = 1'b0;
      chk(dec_out_valid, "R9", "restore valid", 256'(dec_out_valid), 256'd1);
      chk(dec_out_data == mask_len(p, len), "R9", "restored payload", dec_out_data, mask_len(p, len));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [255:0] p, img_a, d0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(in_ready, "R1", "in_ready in reset", 256'(in_ready), 256'd1);
      chk(!out_valid, "R1", "out_valid in reset", 256'(out_valid), 256'd0);
      chk(!dec_out_valid, "R1", "dec_out_valid in reset", 256'(dec_out_valid), 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready && !out_valid && !dec_out_valid, "R1", "idle after reset",
          256'({in_ready, out_valid, dec_out_valid}), 256'd4);

      // table walk: R2, R3, R4, R5, R8, R9
      for (int v = 0; v < 16; v++)
         run_line(pat_line(VEC[v][23:16]), int'(VEC[v][31:24]),
                  int'(VEC[v][15:8]), int'(VEC[v][7:0]));

      // R4/R5: alternating bytes, one-byte words, mask 0x55 in byte 7
      p = '0;
      for (int j = 0; j < 7; j += 2) p[j*8 +: 8] = 8'hFF;
      run_line(p, 7, 1, 1);
      chk(last_img == 256'h55000000_00000000, "R4", "alternating inversion",
          last_img, 256'h55000000_00000000);

      // R6: tag 0 leaves payload untouched
      p = pat_line(8'h3D);
      run_line(p, 16, 0, 2);
      chk(last_img == mask_len(p, 16), "R6", "plain line", last_img, mask_len(p, 16));

      // R7: bytes beyond the length do not matter
      p = pat_line(8'h21);
      run_line(p, 13, 3, 2);
      img_a = last_img;
      p[255:104] = {19{8'hC6}};
      run_line(p, 13, 3, 2);
      chk(last_img == img_a, "R7", "tail ignored", last_img, img_a);

      // R10: back-pressure holds the beat and blocks new lines
      out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_len = 6'd32; in_data = pat_line(8'h77);
      @(negedge clk);
      in_valid = 1'b0;
      d0 = 256'(out_data);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(out_valid && !in_ready && 256'(out_data) == d0, "R10", "held beat",
             256'(out_data), d0);
      end
      out_ready = 1'b1;
      for (int c = 0; c < 8 && out_valid; c++) @(negedge clk);
      chk(!out_valid && in_ready, "R10", "drained", 256'({out_valid, in_ready}), 256'd1);

      // random payloads and worst-case fills at every length: R4, R5, R8, R9
      for (int len = 1; len <= LB; len++) begin
         for (int s = 0; s < 3; s++) begin
            for (int q = 0; q < 8; q++) p[q*32 +: 32] = $urandom;
            run_line(p, len, 0, 0);
         end
         run_line({256{1'b1}}, len, 0, 0);
      end

      summary();
      $finish;
   end
endmodule